// File: doc/BRIEF.md
# Sample FIFO with Data-Available Signalling

This block holds 12-bit conversion results until a host processor collects them. Each sample arrives with a valid strobe and goes into a 16-entry first-in first-out store. The host removes the oldest entry with a pop strobe and reads it on the read-data port. A data-available line tells the host when to come and read. It turns on once the number of stored samples reaches a level chosen by a 2-bit trigger code.

The data-available line can be set at run time in two ways. As a steady level, it stays active for as long as the fill is at or above the trigger. As a one-clock pulse, it fires only when the fill first reaches the trigger. It can also be active high or active low, so it suits edge-sensitive and level-sensitive interrupt inputs. If a sample arrives while the store is full, the sample is lost. This gives a one-clock overflow event and sets a sticky overflow flag. A synchronous clear input empties the store and clears the flag. The control-register decoding that drives these inputs lives outside this block.

Top module: `sample_fifo_dav`

## Requirements
- R1: After the asynchronous active-low reset, the store is empty, rd_data is 0, ovf_evt and ovf_sticky are 0, and dav is at its inactive level.
- R2: Samples leave in the order they were accepted. A pop accepted at a clock edge presents the oldest entry on rd_data after that edge, and rd_data holds that value until the next accepted pop or clear.
- R3: A sample that arrives while 16 entries are held is dropped, even if a pop is accepted in the same cycle. The stored entries are kept unchanged.
- R4: A pop while the store is empty leaves rd_data at its last value and changes no entry or pointer.
- R5: The trigger code selects the fill threshold: 2'b00 gives 1 entry, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R6: With dav_pulse_mode = 0, dav is active in every cycle in which the fill count is at or above the threshold.
- R7: With dav_pulse_mode = 1, dav is active for exactly the one cycle in which the at-or-above condition becomes true after being false in the previous cycle. This includes a rise caused by a change of trigger code.
- R8: With dav_active_high = 1, active means 1 and inactive means 0. With dav_active_high = 0, both levels are inverted.
- R9: ovf_evt is 1 for exactly one cycle, namely the cycle after each dropped sample.
- R10: ovf_sticky becomes 1 together with ovf_evt. It stays 1 until a clear or a reset.
- R11: fifo_clr empties the store at the next edge, sets rd_data to 0 and clears ovf_sticky and ovf_evt. It takes priority over a push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_clr | input | 1 | Synchronous clear of the store and overflow flag |
| smp_valid | input | 1 | A new sample is present on smp_data |
| smp_data | input | 12 | Sample value |
| rd_pop | input | 1 | Host removes the oldest entry |
| trig_code | input | 2 | Fill threshold select |
| dav_pulse_mode | input | 1 | 0: steady level, 1: one-clock pulse |
| dav_active_high | input | 1 | Polarity of dav |
| rd_data | output | 12 | Last entry popped |
| dav | output | 1 | Data-available indication |
| ovf_evt | output | 1 | One-clock overflow event |
| ovf_sticky | output | 1 | Overflow seen since last clear |

## Verification
Some properties are checked on every cycle. A push is never accepted into a full store. A drop is always followed by an overflow event, and only then. The sticky flag holds until a clear. A clear empties the store. An empty pop keeps rd_data stable. The steady-mode level follows the count and polarity, and a pulse never lasts two cycles. Other behaviour only the bench scenarios can show. This covers data ordering through pointer wrap, the exact threshold for each trigger code, the pulse fired by a change of trigger code, and clear taking priority over a push or pop in the same cycle. For these, a queue-based model is compared with the outputs on every clock.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  // Fill threshold for each trigger code
  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // Map an internal active condition onto the chosen output polarity
  function automatic logic apply_pol(input logic act, input logic hi);
    return hi ? act : ~act;
  endfunction

  // Circular pointer advance for any depth
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/sfd_store.sv
module sfd_store #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     count,
  output logic              wr_acc,
  output logic              rd_acc,
  output logic              wr_drop
);
  import sfd_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, empty;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign wr_acc  = wr_req && !full && !clr;
  assign rd_acc  = rd_req && !empty && !clr;
  assign wr_drop = wr_req && full && !clr;

  // One write-enabled register per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_acc && (wr_ptr == AW'(g))) mem[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_data <= '0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      rd_data <= '0;
    end else begin
      if (wr_acc) wr_ptr <= AW'(ptr_next(int'(wr_ptr), DEPTH));
      if (rd_acc) begin
        rd_ptr  <= AW'(ptr_next(int'(rd_ptr), DEPTH));
        rd_data <= mem[rd_ptr];
      end
      case ({wr_acc, rd_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfd_ovf.sv
module sfd_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic drop,
  output logic ovf_evt,
  output logic ovf_sticky
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_evt    <= 1'b0;
      ovf_sticky <= 1'b0;
    end else if (clr) begin
      ovf_evt    <= 1'b0;
      ovf_sticky <= 1'b0;
    end else begin
      ovf_evt <= drop;
      if (drop) ovf_sticky <= 1'b1;
    end
  end
endmodule

// File: rtl/sfd_dav.sv
module sfd_dav #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [1:0]    trig_code,
  input  logic          pulse_mode,
  input  logic          active_high,
  output logic          above,
  output logic          edge_hit,
  output logic          dav
);
  import sfd_pkg::*;

  logic prev_above;
  logic act;

  assign above    = (count >= CW'(trig_level(trig_code)));
  assign edge_hit = above && !prev_above;
  assign act      = pulse_mode ? edge_hit : above;
  assign dav      = apply_pol(act, active_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_above <= 1'b0;
    else        prev_above <= above;
  end
endmodule

// File: rtl/sample_fifo_dav.sv
module sample_fifo_dav #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_clr,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              rd_pop,
  input  logic [1:0]        trig_code,
  input  logic              dav_pulse_mode,
  input  logic              dav_active_high,
  output logic [DATA_W-1:0] rd_data,
  output logic              dav,
  output logic              ovf_evt,
  output logic              ovf_sticky
);
  // Internal events brought out for the checker
  logic [CW-1:0] fill_cnt;
  logic          push_acc;
  logic          pop_acc;
  logic          push_drop;
  logic          lvl_above;
  logic          lvl_edge;

  sfd_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_clr),
    .wr_req  (smp_valid),
    .wr_data (smp_data),
    .rd_req  (rd_pop),
    .rd_data (rd_data),
    .count   (fill_cnt),
    .wr_acc  (push_acc),
    .rd_acc  (pop_acc),
    .wr_drop (push_drop)
  );

  sfd_ovf u_ovf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fifo_clr),
    .drop       (push_drop),
    .ovf_evt    (ovf_evt),
    .ovf_sticky (ovf_sticky)
  );

  sfd_dav #(.DEPTH(DEPTH)) u_dav (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (fill_cnt),
    .trig_code   (trig_code),
    .pulse_mode  (dav_pulse_mode),
    .active_high (dav_active_high),
    .above       (lvl_above),
    .edge_hit    (lvl_edge),
    .dav         (dav)
  );
endmodule

// File: rtl/sample_fifo_dav_chk.sv
module sample_fifo_dav_chk #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_clr,
  input logic              rd_pop,
  input logic [1:0]        trig_code,
  input logic              dav_pulse_mode,
  input logic              dav_active_high,
  input logic [DATA_W-1:0] rd_data,
  input logic              dav,
  input logic              ovf_evt,
  input logic              ovf_sticky,
  input logic [CW-1:0]     fill_cnt,
  input logic              push_acc,
  input logic              push_drop,
  input logic              lvl_edge
);
  import sfd_pkg::*;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH)); // R2
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |-> fill_cnt < CW'(DEPTH)); // R3
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && fill_cnt == '0 && !fifo_clr) |=> $stable(rd_data)); // R4
  AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!dav_pulse_mode && fill_cnt >= CW'(trig_level(trig_code))) |-> dav == dav_active_high); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_edge |=> !lvl_edge); // R7
  AST_DROP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !fifo_clr) |=> ovf_evt); // R9
  AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_evt) |-> $past(push_drop)); // R9
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !fifo_clr) |=> ovf_sticky); // R10
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fill_cnt == '0 && !ovf_sticky && rd_data == '0)); // R11
endmodule

bind sample_fifo_dav sample_fifo_dav_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fifo_clr        (fifo_clr),
  .rd_pop          (rd_pop),
  .trig_code       (trig_code),
  .dav_pulse_mode  (dav_pulse_mode),
  .dav_active_high (dav_active_high),
  .rd_data         (rd_data),
  .dav             (dav),
  .ovf_evt         (ovf_evt),
  .ovf_sticky      (ovf_sticky),
  .fill_cnt        (fill_cnt),
  .push_acc        (push_acc),
  .push_drop       (push_drop),
  .lvl_edge        (lvl_edge)
);

// File: tb/sample_fifo_dav_tb.sv
`timescale 1ns/1ps
module sample_fifo_dav_tb;
  localparam int DW = 12;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_clr = 1'b0, smp_valid = 1'b0, rd_pop = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [1:0] trig_code = 2'b00;
  logic dav_pulse_mode = 1'b0, dav_active_high = 1'b1;
  logic [DW-1:0] rd_data;
  logic dav, ovf_evt, ovf_sticky;

  int errors = 0, checks = 0, cycles = 0;
  bit started = 0, finished = 0;

  // behavioural reference state
  int q[$];
  int m_rd = 0;
  bit m_evt = 0, m_sticky = 0, m_prev = 0;

  always #2 clk = ~clk;

  sample_fifo_dav u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .smp_valid(smp_valid),
    .smp_data(smp_data), .rd_pop(rd_pop), .trig_code(trig_code),
    .dav_pulse_mode(dav_pulse_mode), .dav_active_high(dav_active_high),
    .rd_data(rd_data), .dav(dav), .ovf_evt(ovf_evt), .ovf_sticky(ovf_sticky)
  );

  // R5: threshold table kept in the bench
  function automatic int thr(input logic [1:0] c);
    int t[4] = '{1, 4, 8, 14};
    return t[c];
  endfunction

  function automatic bit exp_dav();
    bit ab, act;
    ab  = (q.size() >= thr(trig_code));
    act = dav_pulse_mode ? (ab && !m_prev) : ab;     // R6, R7
    return dav_active_high ? act : !act;             // R8
  endfunction

  always @(posedge clk) begin
    bit ab;
    cycles++;
    ab = (q.size() >= thr(trig_code));
    if (!rst_n) begin
      q.delete(); m_rd = 0; m_evt = 0; m_sticky = 0; m_prev = 0;
    end else begin
      started = 1;
      m_prev = ab;
      if (fifo_clr) begin                            // R11
        q.delete(); m_rd = 0; m_evt = 0; m_sticky = 0;
      end else begin
        bit full_now;
        full_now = (q.size() == DEP);
        m_evt = smp_valid && full_now;               // R9
        if (m_evt) m_sticky = 1;                     // R10
        if (rd_pop && q.size() > 0) m_rd = q.pop_front(); // R2, R4
        if (smp_valid && !full_now) q.push_back(int'(smp_data)); // R3
      end
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (started && !finished) begin
      chk("R2/R4 rd_data", int'(rd_data), m_rd);
      chk("R5/R6/R7/R8 dav", int'(dav), int'(exp_dav()));
      chk("R9 ovf_evt", int'(ovf_evt), int'(m_evt));
      chk("R10 ovf_sticky", int'(ovf_sticky), int'(m_sticky));
    end
  end

  task automatic cyc(input bit v, input int d, input bit p, input bit c = 0);
    @(negedge clk);
    smp_valid = v; smp_data = DW'(d); rd_pop = p; fifo_clr = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: idle state after reset
    idle(2);
    chk("R1 rd_data reset", int'(rd_data), 0);
    chk("R1 dav inactive", int'(dav), 0);

    // R5/R6 steady, active high, code 00: fill to full
    for (int i = 0; i < DEP; i++) cyc(1, 100 + i, 0);
    // R3/R9/R10: pushes into a full store, then push with pop together
    cyc(1, 7, 0); cyc(1, 8, 0); cyc(1, 9, 1);
    idle(2);
    // R2: drain in order, R4: pops on empty
    for (int i = 0; i < DEP + 3; i++) cyc(0, 0, 1);
    idle(2);

    // R7/R8: pulse mode, active low, code 01
    @(negedge clk); dav_pulse_mode = 1; dav_active_high = 0; trig_code = 2'b01;
    for (int i = 0; i < 6; i++) cyc(1, 200 + i, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);
    for (int i = 0; i < 3; i++) cyc(1, 300 + i, 0);
    idle(2);
    // R7: rise caused by lowering the threshold
    @(negedge clk); trig_code = 2'b11;
    idle(2);
    @(negedge clk); trig_code = 2'b00;
    idle(2);

    // R5: codes 10 and 11 in steady mode, active high
    @(negedge clk); dav_pulse_mode = 0; dav_active_high = 1; trig_code = 2'b10;
    for (int i = 0; i < 12; i++) cyc(1, 400 + i, 0);
    @(negedge clk); trig_code = 2'b11;
    for (int i = 0; i < 4; i++) cyc(1, 500 + i, 0);
    cyc(1, 1, 0);
    // R11: clear wins over push and pop in the same cycle
    cyc(1, 2, 1, 1);
    cyc(0, 0, 0, 0);
    chk("R11 rd_data after clear", int'(rd_data), 0);
    chk("R11 sticky after clear", int'(ovf_sticky), 0);
    idle(2);

    // mixed traffic with all modes
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      smp_valid = ($urandom % 3) != 0;
      smp_data = DW'($urandom);
      rd_pop = ($urandom % 3) == 0;
      fifo_clr = ($urandom % 97) == 0;
      if (i % 50 == 0) begin
        trig_code = 2'($urandom);
        dav_pulse_mode = 1'($urandom);
        dav_active_high = 1'($urandom);
      end
    end
    idle(3);
    finish_run();
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule